// File: doc/BRIEF.md
# Privileged Address Segment Decoder

This block sits beside the load/store pipe of a 32-bit processor with a
privilege model. For every access it looks at the top bits of the virtual
address to find one of five regions. It then checks that region against the
current privilege level and the error-level status flag. The result is one of three:

- an unmapped physical address that is ready to use;
- a request for a TLB lookup;
- a fault.

When a TLB lookup was needed, the block folds the lookup outcome into the fault decision.

The decision path has no registers: the outputs follow the inputs in the same cycle. There is no stream interface, so there is no back-pressure and the caller holds the inputs for as long as it needs the answer. The only state is the three fault registers: the faulting address, the context word, and the entry-high word. They are written on a clock edge when the one-cycle `commit` strobe is high and the current access faults. At all other times they hold.

Top module: `addr_seg_xlate`

## Requirements
- R1: `priv_mode` encoding is 0 = kernel, 1 = supervisor, 2 = user, 3 = user. Address regions are selected by `vaddr[31:29]`: 0 to 3 form the low region, 4 is the cached direct region, 5 is the uncached direct region, 6 is the supervisor mapped region and 7 is the kernel mapped region.
- R2: In the low region with `err_level` clear, every mode gets `need_tlb`=1 and `pa_valid`=0. With `err_level` set, the block gives `pa_valid`=1 with `paddr`=`vaddr`, and `need_tlb`=0.
- R3: Regions 4 and 5 are open to kernel only. For a kernel access they give `pa_valid`=1, `need_tlb`=0 and `paddr` = {3'b000, `vaddr[28:0]`}.
- R4: Region 6 is open to kernel and supervisor, and region 7 to kernel only. Both are mapped, so an allowed access gives `need_tlb`=1.
- R5: An access that the privilege rules do not allow raises `fault`. It gives `exc_code` 5 for a store and 4 for a load, with `need_tlb`=0 and `pa_valid`=0.
- R6: `tlb_res` encoding is 0 = hit, 1 = no match, 2 = invalid, 3 = write to a clean page. An allowed mapped access faults as follows: with result 1 or 2, `exc_code` is 3 for a store and 2 for a load; with result 3, `exc_code` is 1. With result 0 there is no fault.
- R7: `refill` is 1 exactly when an allowed mapped access sees result 1.
- R8: Whenever there is no fault, `exc_code` is 0. Whenever `pa_valid` is 0, `paddr` is 0. `pa_valid` and `need_tlb` are never 1 together.
- R9: On a clock edge with `commit` and `fault` both high, `badaddr_q` takes `vaddr`. `context_q[22:4]` takes `vaddr[31:13]`, and the other bits of `context_q` keep their value. `entryhi_q` takes {`vaddr[31:13]`, 5'b0, `asid`}.
- R10: The three fault registers do not change on any edge where `commit` or `fault` is low, and all three are zero after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| vaddr | input | 32 | Virtual address of the access |
| is_store | input | 1 | 1 = write, 0 = read |
| priv_mode | input | 2 | Privilege level (R1) |
| err_level | input | 1 | Error-level status flag |
| tlb_res | input | 2 | TLB lookup outcome (R6) |
| asid | input | 8 | Current address-space identifier |
| commit | input | 1 | Fault register write strobe |
| need_tlb | output | 1 | Address must be translated by the TLB |
| pa_valid | output | 1 | `paddr` holds an unmapped translation |
| paddr | output | 32 | Unmapped physical address |
| fault | output | 1 | Access faults |
| exc_code | output | 5 | Exception cause code |
| refill | output | 1 | Fault is a TLB miss in a mapped region |
| badaddr_q | output | 32 | Faulting address register |
| context_q | output | 32 | Context register |
| entryhi_q | output | 32 | Entry-high register |

## Verification
A decode error, such as a wrong region boundary or a wrong privilege test, shows on `need_tlb`, `pa_valid`, `fault` or `exc_code` in the same cycle as the bad input, because none of those paths holds state. A fault register that captures the wrong data, captures at the wrong time, or loses its preserved context bits shows on the register outputs one edge after the commit. It then stays visible until the next faulting commit. The sweep crosses every region with several offsets, every mode, both flag values, both directions and all TLB outcomes, so every corner of the decision table is compared.

// File: rtl/seg_pkg.sv
package seg_pkg;
  localparam int AW = 32;

  typedef enum logic [1:0] {
    PRIV_KERN = 2'd0,
    PRIV_SUP  = 2'd1,
    PRIV_USER = 2'd2,
    PRIV_RSVD = 2'd3
  } priv_e;

  typedef enum logic [1:0] {
    TLB_HIT     = 2'd0,
    TLB_MISS    = 2'd1,
    TLB_INVALID = 2'd2,
    TLB_CLEAN   = 2'd3
  } tlb_res_e;

  localparam logic [4:0] EXC_NONE   = 5'd0;
  localparam logic [4:0] EXC_MODIFY = 5'd1;
  localparam logic [4:0] EXC_TLB_LD = 5'd2;
  localparam logic [4:0] EXC_TLB_ST = 5'd3;
  localparam logic [4:0] EXC_ADR_LD = 5'd4;
  localparam logic [4:0] EXC_ADR_ST = 5'd5;
endpackage

// File: rtl/seg_decode.sv
module seg_decode
  import seg_pkg::*;
(
  input  logic [AW-1:0] vaddr,
  input  priv_e         mode,
  input  logic          err_level,
  output logic          allowed,
  output logic          mapped,
  output logic [AW-1:0] paddr_unm
);
  logic is_kern, is_sup;

  always_comb begin
    is_kern = (mode == PRIV_KERN);
    is_sup  = (mode == PRIV_SUP);
    allowed   = 1'b0;
    mapped    = 1'b0;
    paddr_unm = '0;
    if (!vaddr[AW-1]) begin
      allowed = 1'b1;
      mapped  = !err_level;
      if (err_level) paddr_unm = vaddr;
    end else begin
      unique case (vaddr[AW-2:AW-3])
        2'b00, 2'b01: begin
          allowed   = is_kern;
          mapped    = 1'b0;
          paddr_unm = {3'b000, vaddr[AW-4:0]};
        end
        2'b10: begin
          allowed = is_kern || is_sup;
          mapped  = 1'b1;
        end
        default: begin
          allowed = is_kern;
          mapped  = 1'b1;
        end
      endcase
    end
  end
endmodule

// File: rtl/fault_encode.sv
module fault_encode
  import seg_pkg::*;
(
  input  logic     allowed,
  input  logic     mapped,
  input  logic     is_store,
  input  tlb_res_e tlb_res,
  output logic     fault,
  output logic [4:0] exc_code,
  output logic     refill
);
  always_comb begin
    fault    = 1'b0;
    exc_code = EXC_NONE;
    refill   = 1'b0;
    if (!allowed) begin
      fault    = 1'b1;
      exc_code = is_store ? EXC_ADR_ST : EXC_ADR_LD;
    end else if (mapped) begin
      unique case (tlb_res)
        TLB_MISS, TLB_INVALID: begin
          fault    = 1'b1;
          exc_code = is_store ? EXC_TLB_ST : EXC_TLB_LD;
          refill   = (tlb_res == TLB_MISS);
        end
        TLB_CLEAN: begin
          fault    = 1'b1;
          exc_code = EXC_MODIFY;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/fault_regs.sv
module fault_regs
  import seg_pkg::*;
#(
  parameter int ASID_W    = 8,
  parameter int PAGE_BITS = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              capture,
  input  logic [AW-1:0]     vaddr,
  input  logic [ASID_W-1:0] asid,
  output logic [AW-1:0]     badaddr_q,
  output logic [AW-1:0]     context_q,
  output logic [AW-1:0]     entryhi_q
);
  localparam int VPN2_LSB = PAGE_BITS + 1;
  localparam int VPN2_W   = AW - VPN2_LSB;
  localparam int CTX_LO   = 4;
  localparam int CTX_HI   = CTX_LO + VPN2_W - 1;
  localparam int GAP_W    = VPN2_LSB - ASID_W;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      badaddr_q <= '0;
      context_q <= '0;
      entryhi_q <= '0;
    end else if (capture) begin
      badaddr_q <= vaddr;
      context_q <= {context_q[AW-1:CTX_HI+1], vaddr[AW-1:VPN2_LSB],
                    context_q[CTX_LO-1:0]};
      entryhi_q <= {vaddr[AW-1:VPN2_LSB], {GAP_W{1'b0}}, asid};
    end
  end

  a_r9_badaddr: assert property (@(posedge clk) disable iff (!rst_n)
    capture |=> badaddr_q == $past(vaddr));
  a_r9_entryhi_asid: assert property (@(posedge clk) disable iff (!rst_n)
    capture |=> entryhi_q[ASID_W-1:0] == $past(asid));
  a_r9_ctx_kept: assert property (@(posedge clk) disable iff (!rst_n)
    capture |=> context_q[CTX_LO-1:0] == $past(context_q[CTX_LO-1:0]));
  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !capture |=> $stable(badaddr_q) && $stable(context_q) && $stable(entryhi_q));
endmodule

// File: rtl/addr_seg_xlate.sv
module addr_seg_xlate
  import seg_pkg::*;
#(
  parameter int ASID_W    = 8,
  parameter int PAGE_BITS = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [31:0]       vaddr,
  input  logic              is_store,
  input  logic [1:0]        priv_mode,
  input  logic              err_level,
  input  logic [1:0]        tlb_res,
  input  logic [ASID_W-1:0] asid,
  input  logic              commit,
  output logic              need_tlb,
  output logic              pa_valid,
  output logic [31:0]       paddr,
  output logic              fault,
  output logic [4:0]        exc_code,
  output logic              refill,
  output logic [31:0]       badaddr_q,
  output logic [31:0]       context_q,
  output logic [31:0]       entryhi_q
);
  logic          allowed, mapped;
  logic [AW-1:0] paddr_unm;

  seg_decode u_dec (
    .vaddr     (vaddr),
    .mode      (priv_e'(priv_mode)),
    .err_level (err_level),
    .allowed   (allowed),
    .mapped    (mapped),
    .paddr_unm (paddr_unm)
  );

  fault_encode u_enc (
    .allowed  (allowed),
    .mapped   (mapped),
    .is_store (is_store),
    .tlb_res  (tlb_res_e'(tlb_res)),
    .fault    (fault),
    .exc_code (exc_code),
    .refill   (refill)
  );

  assign need_tlb = allowed && mapped;
  assign pa_valid = allowed && !mapped;
  assign paddr    = pa_valid ? paddr_unm : '0;

  fault_regs #(.ASID_W(ASID_W), .PAGE_BITS(PAGE_BITS)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .capture   (commit && fault),
    .vaddr     (vaddr),
    .asid      (asid),
    .badaddr_q (badaddr_q),
    .context_q (context_q),
    .entryhi_q (entryhi_q)
  );

  a_r8_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(need_tlb && pa_valid));
  a_r3_direct: assert property (@(posedge clk) disable iff (!rst_n)
    (vaddr[31:30] == 2'b10 && priv_mode == 2'd0) |->
      (pa_valid && paddr[31:29] == 3'b000 && paddr[28:0] == vaddr[28:0]));
  a_r5_user_high: assert property (@(posedge clk) disable iff (!rst_n)
    (vaddr[31] && priv_mode[1]) |->
      (fault && !need_tlb && exc_code == (is_store ? 5'd5 : 5'd4)));
  a_r7_refill: assert property (@(posedge clk) disable iff (!rst_n)
    refill |-> (fault && need_tlb && tlb_res == 2'd1));
endmodule

// File: tb/tb_addr_seg_xlate.sv
module tb_addr_seg_xlate;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] vaddr = '0;
  logic        is_store = 1'b0;
  logic [1:0]  priv_mode = '0;
  logic        err_level = 1'b0;
  logic [1:0]  tlb_res = '0;
  logic [7:0]  asid = '0;
  logic        commit = 1'b0;
  logic        need_tlb, pa_valid, fault, refill;
  logic [31:0] paddr, badaddr_q, context_q, entryhi_q;
  logic [4:0]  exc_code;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  addr_seg_xlate dut (
    .clk(clk), .rst_n(rst_n), .vaddr(vaddr), .is_store(is_store),
    .priv_mode(priv_mode), .err_level(err_level), .tlb_res(tlb_res),
    .asid(asid), .commit(commit), .need_tlb(need_tlb), .pa_valid(pa_valid),
    .paddr(paddr), .fault(fault), .exc_code(exc_code), .refill(refill),
    .badaddr_q(badaddr_q), .context_q(context_q), .entryhi_q(entryhi_q)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  logic [31:0] m_bad = '0, m_ctx = '0, m_ehi = '0;

  initial begin
    logic [28:0] offs [4];
    offs[0] = 29'h0000_0000; offs[1] = 29'h1FFF_FFFF;
    offs[2] = 29'h0A5C_3E7F; offs[3] = 29'h1234_5678;
    repeat (3) @(posedge clk);
    #1;
    chk("R10", "reset badaddr", badaddr_q, 32'h0);
    chk("R10", "reset context", context_q, 32'h0);
    chk("R10", "reset entryhi", entryhi_q, 32'h0);
    rst_n = 1'b1;
    for (int rg = 0; rg < 8; rg++)
      for (int oi = 0; oi < 4; oi++)
        for (int md = 0; md < 4; md++)
          for (int el = 0; el < 2; el++)
            for (int st = 0; st < 2; st++)
              for (int tr = 0; tr < 4; tr++) begin
                logic al, mp, ef, er, do_commit;
                logic [31:0] a, epa;
                logic [4:0] ec;
                logic kern, sup;
                @(negedge clk);
                a = {rg[2:0], offs[oi]};
                do_commit = ((rg + oi + md + tr) % 3) != 0;
                vaddr = a; priv_mode = md[1:0]; err_level = el[0];
                is_store = st[0]; tlb_res = tr[1:0];
                asid = 8'(rg * 37 + oi * 11 + md * 5 + tr);
                commit = do_commit;
                kern = (md == 0); sup = (md == 1);
                epa = '0;
                if (rg < 4) begin al = 1; mp = !el[0]; if (el[0]) epa = a; end
                else if (rg < 6) begin al = kern; mp = 0; epa = {3'b0, a[28:0]}; end
                else if (rg == 6) begin al = kern || sup; mp = 1; end
                else begin al = kern; mp = 1; end
                ef = 0; ec = 0; er = 0;
                if (!al) begin ef = 1; ec = st[0] ? 5'd5 : 5'd4; end
                else if (mp && (tr == 1 || tr == 2)) begin
                  ef = 1; ec = st[0] ? 5'd3 : 5'd2; er = (tr == 1);
                end else if (mp && tr == 3) begin ef = 1; ec = 5'd1; end
                if (!(al && !mp)) epa = '0;
                #1;
                // R1 R2 R3 R4 decode, R5 R6 fault code, R7 refill, R8 idle values
                chk(rg < 4 ? "R2" : (rg < 6 ? "R3" : "R4"), "need_tlb", 32'(need_tlb), 32'(al && mp));
                chk(rg < 4 ? "R2" : "R3", "pa_valid", 32'(pa_valid), 32'(al && !mp));
                chk("R8", "paddr", paddr, epa);
                chk(al ? "R6" : "R5", "fault", 32'(fault), 32'(ef));
                chk(al ? "R6" : "R5", "exc_code", 32'(exc_code), 32'(ec));
                chk("R7", "refill", 32'(refill), 32'(er));
                if (do_commit && ef) begin
                  m_bad = a;
                  m_ctx = {m_ctx[31:23], a[31:13], m_ctx[3:0]};
                  m_ehi = {a[31:13], 5'b0, asid};
                end
                @(posedge clk);
                #1;
                commit = 1'b0;
                chk(do_commit && ef ? "R9" : "R10", "badaddr_q", badaddr_q, m_bad);
                chk(do_commit && ef ? "R9" : "R10", "context_q", context_q, m_ctx);
                chk(do_commit && ef ? "R9" : "R10", "entryhi_q", entryhi_q, m_ehi);
              end
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule